// File: doc/BRIEF.md
# Transmit Automatic Level Controller

This block picks the gain code for a transmitter's output stage at the start of every outgoing frame. A fed-back copy of the transmitted waveform arrives as signed samples with the DC part already removed. The block keeps the largest magnitude seen during a short measurement window. When the window closes, it compares that peak with a lower and an upper threshold. A peak under the lower bound moves the gain code up by one step, and a peak over the upper bound moves it down by one step. In the intended use the upper bound is one and a half times the lower one.

Adaptation runs only while the first two bits of a frame are on the line. That two-bit span is cut into eight equal windows, so the gain code is stepped at most eight times. It is then frozen and a done flag is raised until the next frame begins. Timing comes from a sub-bit tick strobe that fires a fixed number of times per bit. The gain code carries over from one frame to the next, and only reset returns it to mid-scale.

Top module: `tx_level_ctrl`

## Requirements
- R1: While reset is low and after it is released, the gain code is mid-scale (2^(GAIN_W-1)) and the done flag is 0.
- R2: The magnitude of a sample is its absolute value. The most negative code (sign bit 1, all other bits 0) counts as the largest positive magnitude (all MAG_W bits 1). Only samples with `smp_valid` high are measured.
- R3: If the window's peak is strictly below `thr_lo`, the gain code rises by exactly one.
- R4: If the window's peak is strictly above `thr_hi`, the gain code falls by exactly one. When the peak is also below `thr_lo`, R3 takes precedence.
- R5: If the peak lies in the closed range from `thr_lo` to `thr_hi`, the gain code is unchanged.
- R6: The gain code saturates at 0 and at 2^GAIN_W-1 and never wraps.
- R7: A window spans TICKS_PER_BIT*2/8 cycles in which `sub_tick` is high. The peak restarts from zero in each window. The decision includes the sample presented in the same cycle as the closing tick, and the gain code changes on that clock edge. Cycles with `sub_tick` low do not advance the window.
- R8: Each frame makes exactly eight decisions. On the edge of the eighth decision, `adapt_done` goes to 1. It stays at 1, and the gain code stays unchanged under any samples and ticks, until the next `frame_start`.
- R9: A `frame_start` pulse clears `adapt_done` on the next edge and begins a fresh set of eight windows, even in the middle of a frame. The gain code carries over across frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | One-cycle strobe marking the start of a new frame |
| sub_tick | input | 1 | Strobe pulsing TICKS_PER_BIT times per transmitted bit |
| smp_valid | input | 1 | Qualifies `smp_data` |
| smp_data | input | SAMPLE_W | Signed, DC-free sample of the fed-back transmit signal |
| thr_lo | input | SAMPLE_W-1 | Lower peak threshold (unsigned magnitude) |
| thr_hi | input | SAMPLE_W-1 | Upper peak threshold (unsigned magnitude) |
| gain_code | output | GAIN_W | Current gain setting |
| adapt_done | output | 1 | High after the eighth decision of a frame, until the next frame starts |

## Verification
The bench runs about twenty frames on a small configuration. It steers each window's peak to one of five classes: one below the lower bound, exactly on each bound, one above the upper bound, and the most negative code. These classes separate the three decision outcomes and test that both range ends count as inclusive. Runs of all-low and all-high frames drive the code into both saturation limits. Alternating the position and sign of the peak sample, adding non-tick gap cycles and sending invalid junk samples show whether the window boundaries and the valid qualifier are respected. Ticks after the eighth decision and a restart in the middle of a frame check the freeze and the restart.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
   typedef enum logic [1:0] {
      GSTEP_HOLD = 2'd0,
      GSTEP_UP   = 2'd1,
      GSTEP_DOWN = 2'd2
   } gstep_e;
endpackage

// File: rtl/tlc_peak_track.sv
module tlc_peak_track #(
   parameter int SAMPLE_W = 12,
   localparam int MAG_W   = SAMPLE_W - 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear,
   input  logic                enable,
   input  logic                smp_valid,
   input  logic [SAMPLE_W-1:0] smp_data,
   output logic [MAG_W-1:0]    peak_q,
   output logic [MAG_W-1:0]    peak_next
);
   logic [SAMPLE_W-1:0] negated;
   logic [MAG_W-1:0]    mag;

   assign negated = (~smp_data) + 1'b1;

   always_comb begin
      if (!smp_data[SAMPLE_W-1])
         mag = smp_data[MAG_W-1:0];
      else if (smp_data[MAG_W-1:0] == '0)
         mag = '1;
      else
         mag = negated[MAG_W-1:0];
   end

   always_comb begin
      peak_next = peak_q;
      if (enable && smp_valid && (mag > peak_q))
         peak_next = mag;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         peak_q <= '0;
      else if (clear)
         peak_q <= '0;
      else
         peak_q <= peak_next;
   end

   assert_peak_monotone_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> (peak_q >= $past(peak_q)));
endmodule

// File: rtl/tlc_window_seq.sv
module tlc_window_seq #(
   parameter int TICKS_PER_WIN = 4,
   parameter int STEPS         = 8,
   localparam int TW = (TICKS_PER_WIN > 1) ? $clog2(TICKS_PER_WIN) : 1,
   localparam int SW = $clog2(STEPS)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_start,
   input  logic tick,
   output logic active,
   output logic win_end,
   output logic done
);
   logic          last_tick;
   logic [SW-1:0] win_cnt;

   generate
      if (TICKS_PER_WIN == 1) begin : g_single_tick
         assign last_tick = tick;
      end else begin : g_tick_count
         logic [TW-1:0] tick_cnt;
         assign last_tick = tick && (tick_cnt == TW'(TICKS_PER_WIN - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               tick_cnt <= '0;
            else if (frame_start)
               tick_cnt <= '0;
            else if (active && tick)
               tick_cnt <= last_tick ? '0 : tick_cnt + 1'b1;
         end
      end
   endgenerate

   assign win_end = active && last_tick && !frame_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         done    <= 1'b0;
         win_cnt <= '0;
      end else if (frame_start) begin
         active  <= 1'b1;
         done    <= 1'b0;
         win_cnt <= '0;
      end else if (win_end) begin
         win_cnt <= win_cnt + 1'b1;
         if (win_cnt == SW'(STEPS - 1)) begin
            active <= 1'b0;
            done   <= 1'b1;
         end
      end
   end

   assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !frame_start) |=> done);
   assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (active && !done));
   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !active);
endmodule

// File: rtl/tlc_gain_step.sv
module tlc_gain_step #(
   parameter int MAG_W  = 11,
   parameter int GAIN_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              decide,
   input  logic [MAG_W-1:0]  peak,
   input  logic [MAG_W-1:0]  thr_lo,
   input  logic [MAG_W-1:0]  thr_hi,
   output logic [GAIN_W-1:0] gain
);
   import tlc_pkg::*;

   localparam logic [GAIN_W-1:0] GAIN_MID = GAIN_W'(1) << (GAIN_W - 1);
   localparam logic [GAIN_W-1:0] GAIN_MAX = '1;

   gstep_e step;

   always_comb begin
      if (peak < thr_lo)
         step = GSTEP_UP;
      else if (peak > thr_hi)
         step = GSTEP_DOWN;
      else
         step = GSTEP_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gain <= GAIN_MID;
      else if (decide) begin
         case (step)
            GSTEP_UP:   if (gain != GAIN_MAX) gain <= gain + 1'b1;
            GSTEP_DOWN: if (gain != '0)       gain <= gain - 1'b1;
            default:    gain <= gain;
         endcase
      end
   end

   assert_gain_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !decide |=> $stable(gain));
   assert_gain_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      decide |=> (gain == $past(gain) || gain == GAIN_W'($past(gain) + 1'b1)
                  || gain == GAIN_W'($past(gain) - 1'b1)));
   assert_no_wrap_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (gain == GAIN_MAX) |=> (gain != '0));
   assert_no_wrap_bottom_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (gain == '0) |=> (gain != GAIN_MAX));
endmodule

// File: rtl/tx_level_ctrl.sv
module tx_level_ctrl #(
   parameter int SAMPLE_W      = 12,
   parameter int GAIN_W        = 5,
   parameter int TICKS_PER_BIT = 16,
   parameter int ADAPT_BITS    = 2,
   parameter int ADAPT_STEPS   = 8,
   localparam int MAG_W         = SAMPLE_W - 1,
   localparam int TICKS_PER_WIN = (TICKS_PER_BIT * ADAPT_BITS) / ADAPT_STEPS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                frame_start,
   input  logic                sub_tick,
   input  logic                smp_valid,
   input  logic [SAMPLE_W-1:0] smp_data,
   input  logic [MAG_W-1:0]    thr_lo,
   input  logic [MAG_W-1:0]    thr_hi,
   output logic [GAIN_W-1:0]   gain_code,
   output logic                adapt_done
);
   initial begin
      assert (SAMPLE_W >= 3) else $error("SAMPLE_W must be at least 3");
      assert (GAIN_W >= 2) else $error("GAIN_W must be at least 2");
      assert (ADAPT_STEPS >= 2) else $error("ADAPT_STEPS must be at least 2");
      assert ((TICKS_PER_BIT * ADAPT_BITS) % ADAPT_STEPS == 0 && TICKS_PER_WIN >= 1)
         else $error("adaptation span must split evenly into windows");
   end

   logic             active;
   logic             win_end;
   logic [MAG_W-1:0] peak_q;
   logic [MAG_W-1:0] peak_next;

   tlc_window_seq #(
      .TICKS_PER_WIN (TICKS_PER_WIN),
      .STEPS         (ADAPT_STEPS)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .tick        (sub_tick),
      .active      (active),
      .win_end     (win_end),
      .done        (adapt_done)
   );

   tlc_peak_track #(
      .SAMPLE_W (SAMPLE_W)
   ) u_peak (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (frame_start || win_end),
      .enable    (active),
      .smp_valid (smp_valid),
      .smp_data  (smp_data),
      .peak_q    (peak_q),
      .peak_next (peak_next)
   );

   tlc_gain_step #(
      .MAG_W  (MAG_W),
      .GAIN_W (GAIN_W)
   ) u_gain (
      .clk    (clk),
      .rst_n  (rst_n),
      .decide (win_end),
      .peak   (peak_next),
      .thr_lo (thr_lo),
      .thr_hi (thr_hi),
      .gain   (gain_code)
   );

   assert_peak_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
      win_end |=> (peak_q == '0));
   assert_idle_peak_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !frame_start) |=> (peak_q == '0));
endmodule

// File: tb/tx_level_ctrl_bench.sv
`timescale 1ns/1ps
module tx_level_ctrl_bench;
   localparam int SW   = 6;
   localparam int GW   = 3;
   localparam int TPB  = 8;
   localparam int MW   = SW - 1;
   localparam int GMAX = (1 << GW) - 1;
   localparam int LO   = 8;
   localparam int HI   = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame_start = 1'b0;
   logic          sub_tick = 1'b0;
   logic          smp_valid = 1'b0;
   logic [SW-1:0] smp_data = '0;
   logic [MW-1:0] thr_lo = MW'(LO);
   logic [MW-1:0] thr_hi = MW'(HI);
   logic [GW-1:0] gain_code;
   logic          adapt_done;

   int n_chk = 0;
   int n_fail = 0;
   int exp_gain = 1 << (GW - 1);
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   tx_level_ctrl #(
      .SAMPLE_W (SW), .GAIN_W (GW), .TICKS_PER_BIT (TPB)
   ) u_tx_level_ctrl (
      .clk (clk), .rst_n (rst_n), .frame_start (frame_start), .sub_tick (sub_tick),
      .smp_valid (smp_valid), .smp_data (smp_data), .thr_lo (thr_lo), .thr_hi (thr_hi),
      .gain_code (gain_code), .adapt_done (adapt_done)
   );

   task automatic chk(input string req, input int act, input int expv);
      n_chk++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic drive(input bit fs, input bit tk, input bit vl, input int s);
      @(negedge clk);
      frame_start = fs; sub_tick = tk; smp_valid = vl; smp_data = SW'(s);
   endtask

   task automatic settle();
      @(posedge clk); #1;
   endtask

   // R9: frame start clears the done flag on the next edge
   task automatic start_frame();
      drive(1'b1, 1'b0, 1'b0, 0);
      settle();
      chk("R9 done cleared", int'(adapt_done), 0);
   endtask

   // kinds: 0 below lo (R3), 1 at lo (R5), 2 at hi (R5), 3 above hi (R4), 4 most negative (R2)
   task automatic run_window(input int kind, input int w, input bit gap, input int wins_done);
      int tgt;
      int mag;
      case (kind)
         0: tgt = LO - 1;
         1: tgt = LO;
         2: tgt = HI;
         3: tgt = HI + 1;
         default: tgt = -(1 << (SW - 1));
      endcase
      mag = (kind == 4) ? (1 << MW) - 1 : tgt;
      if (gap) drive(1'b0, 1'b0, 1'b1, -1);           // R7: no tick, does not advance
      if (w % 2 == 0) begin
         drive(1'b0, 1'b1, 1'b1, tgt);
         drive(1'b0, 1'b1, 1'b1, -2);
      end else begin
         drive(1'b0, 1'b1, 1'b0, -(1 << (SW - 1)));   // R2: invalid junk ignored
         drive(1'b0, 1'b1, 1'b1, (kind == 4) ? tgt : -tgt);
      end
      settle();
      if (mag < LO) begin
         if (exp_gain < GMAX) exp_gain++;
      end else if (mag > HI) begin
         if (exp_gain > 0) exp_gain--;
      end
      case (kind)
         0: chk("R3 below low steps up (R6 cap)", int'(gain_code), exp_gain);
         3: chk("R4 above high steps down (R6 floor)", int'(gain_code), exp_gain);
         4: chk("R2 most negative as max magnitude", int'(gain_code), exp_gain);
         default: chk("R5 inclusive band holds", int'(gain_code), exp_gain);
      endcase
      chk("R8 done after eighth decision", int'(adapt_done), (wins_done == 8) ? 1 : 0);
   endtask

   function automatic int pick(input int f, input int w);
      if (f % 5 == 0 || f == 2) return 0;
      if (f % 5 == 1 || f == 7) return 3;
      return (f * 3 + w * 7) % 5;
   endfunction

   initial begin
      #1_000_000;
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 gain mid-scale in reset", int'(gain_code), 1 << (GW - 1));
      chk("R1 done low in reset", int'(adapt_done), 0);
      @(negedge clk); rst_n = 1'b1;
      settle();
      chk("R1 gain mid-scale after reset", int'(gain_code), 1 << (GW - 1));

      // R8: ticks before any frame are ignored
      for (int i = 0; i < 4; i++) drive(1'b0, 1'b1, 1'b1, 0);
      settle();
      chk("R8 idle ticks ignored", int'(gain_code), exp_gain);

      for (int f = 0; f < 20; f++) begin
         start_frame();
         for (int w = 0; w < 8; w++) run_window(pick(f, w), w + f, f % 2 == 1, w + 1);
         // R8: frozen after eighth decision
         for (int i = 0; i < 6; i++) drive(1'b0, 1'b1, 1'b1, (f % 2) ? 0 : 31);
         settle();
         chk("R8 gain frozen after burst", int'(gain_code), exp_gain);
         chk("R8 done held", int'(adapt_done), 1);
         // R9: gain carries across frames
         chk("R9 gain kept before next frame", int'(gain_code), exp_gain);
      end

      // R9: restart in the middle of a frame
      start_frame();
      for (int w = 0; w < 3; w++) run_window(3, w, 1'b0, w + 1);
      start_frame();
      for (int w = 0; w < 8; w++) run_window(0, w, 1'b0, w + 1);
      drive(1'b0, 1'b0, 1'b0, 0);
      settle();
      chk("R9 restart gives full burst", int'(adapt_done), 1);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule